// File: doc/BRIEF.md
# Three-Lane Serial-to-Parallel Frame Receiver

This block takes three serial data lanes and one forwarded-clock lane, all already sampled once per bit slot by a clock that runs at seven times the frame rate. It shifts seven bits in from each lane and watches the clock lane for its fixed framing shape. Once the shape has repeated on two frames in a row, it rebuilds each frame into one 21-bit parallel word and marks it with a one-cycle strobe.

Every delivered word has the same fixed latency of two frame periods, counted from the first bit of the frame. If the clock lane stops showing the framing shape at a frame boundary, the block drops lock and searches again. A power-down input clears all internal state and forces every parallel output to zero for as long as it is held.

Top module: `desrx_top`

## Requirements
- R1: The bit that lane L carries in arrival slot i of a frame (slot 0 arrives first) appears at bit 7*L+i of `word_o`.
- R2: A frame matches when the clock lane carries 1,1,1,1,0,0,0 in slots 0 to 6. This is the cyclic 1100011 shape, with the frame starting at its 0-to-1 edge. The first word delivered after a search is the second of two matching frames in a row.
- R3: `valid_o` is high for exactly one cycle for each delivered frame and is never high otherwise. Consecutive strobes are at least seven cycles apart.
- R4: `word_o` and `valid_o` update on the eighth rising edge after the edge that samples slot 6 of the frame. That is fourteen edges, or two frame periods, after slot 0.
- R5: A frame whose clock-lane slots do not match at an expected boundary is not delivered and drops lock. Two new matching frames are then needed before the next delivery.
- R6: A word already captured before lock is lost is still delivered at its normal time.
- R7: While `pdown` is high, `word_o` and `valid_o` are zero.
- R8: Power-down discards lock and every captured word that has not yet been output. After `pdown` falls, two matching frames must arrive again before the next delivery.
- R9: After reset, `word_o` and `valid_o` are zero.
- R10: Between strobes, and outside power-down, `word_o` keeps the last delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock, seven cycles per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdown | input | 1 | Power-down; clears state and holds outputs low |
| rx_clk_lane | input | 1 | Sampled forwarded-clock lane |
| rx_dat_lane | input | 3 | Sampled data lanes, bit L is lane L |
| word_o | output | 21 | Rebuilt parallel word |
| valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
Lock loss and delivery of the previous word fall on the same clock edge. A mismatching frame right after a locked frame ends on the edge where the earlier word is due at the output. The bench sends random bad frames between good ones to provoke this, and it expects the earlier word to arrive on time while the bad frame and the next good frame produce nothing. Power-down is also asserted on the first slot after a frame ends, so it lands on the capture edge of that frame. The bench then checks that neither that word nor any word still in flight ever appears.

// File: rtl/desrx_pkg.sv
package desrx_pkg;
  localparam int unsigned SLOTS = 7;
  localparam int unsigned CW    = $clog2(SLOTS);
  // bit i of the window holds arrival slot i
  localparam logic [SLOTS-1:0] CLK_SHAPE = 7'b0001111;
  typedef enum logic [1:0] {FR_HUNT, FR_VERIFY, FR_LOCK} fr_state_e;
endpackage

// File: rtl/desrx_lane_shift.sv
module desrx_lane_shift
  import desrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             din,
  output logic [SLOTS-1:0] win
);
  logic [SLOTS-1:0] win_nxt;

  // newest bit enters at the top, so slot 0 ends at bit 0
  always_comb begin
    if (clr) win_nxt = '0;
    else     win_nxt = {din, win[SLOTS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= win_nxt;
  end
endmodule

// File: rtl/desrx_framer.sv
module desrx_framer
  import desrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SLOTS-1:0] ck_win,
  output logic             capture,
  output logic             locked
);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  fr_state_e       st, st_nxt;
  logic [CW-1:0]   slot, slot_nxt;
  logic            hit;

  assign hit    = (ck_win == CLK_SHAPE);
  assign locked = (st == FR_LOCK);

  always_comb begin
    st_nxt   = st;
    slot_nxt = (slot == LAST) ? '0 : slot + 1'b1;
    capture  = 1'b0;
    unique case (st)
      FR_HUNT: begin
        if (hit) begin
          st_nxt   = FR_VERIFY;
          slot_nxt = '0;
        end
      end
      FR_VERIFY: begin
        if (slot == LAST) begin
          st_nxt  = hit ? FR_LOCK : FR_HUNT;
          capture = hit;
        end
      end
      FR_LOCK: begin
        if (slot == LAST) begin
          if (hit) capture = 1'b1;
          else     st_nxt  = FR_HUNT;
        end
      end
      default: st_nxt = FR_HUNT;
    endcase
    if (clr) begin
      st_nxt   = FR_HUNT;
      slot_nxt = '0;
      capture  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FR_HUNT;
      slot <= '0;
    end else begin
      st   <= st_nxt;
      slot <= slot_nxt;
    end
  end
endmodule

// File: rtl/desrx_out_stage.sv
module desrx_out_stage
  import desrx_pkg::*;
#(
  parameter int unsigned DW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          capture,
  input  logic [DW-1:0] par,
  output logic [DW-1:0] word_q,
  output logic          valid_q
);
  logic [DW-1:0]    hold, hold_nxt, word_nxt;
  logic [SLOTS-1:0] dly, dly_nxt;
  logic             valid_nxt, hold_en, word_en;

  assign hold_en = capture;
  assign word_en = dly[SLOTS-1];

  always_comb begin
    hold_nxt  = hold_en ? par : hold;
    dly_nxt   = {dly[SLOTS-2:0], capture};
    word_nxt  = word_en ? hold : word_q;
    valid_nxt = word_en;
    if (clr) begin
      hold_nxt  = '0;
      dly_nxt   = '0;
      word_nxt  = '0;
      valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      dly     <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      hold    <= hold_nxt;
      dly     <= dly_nxt;
      word_q  <= word_nxt;
      valid_q <= valid_nxt;
    end
  end
endmodule

// File: rtl/desrx_top.sv
module desrx_top
  import desrx_pkg::*;
#(
  parameter int unsigned LANES = 3,
  localparam int unsigned DW   = LANES * SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdown,
  input  logic             rx_clk_lane,
  input  logic [LANES-1:0] rx_dat_lane,
  output logic [DW-1:0]    word_o,
  output logic             valid_o
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [SLOTS-1:0] ck_win;
  logic [DW-1:0]    par;
  logic [DW-1:0]    word_q;
  logic             valid_q, capture, locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  desrx_lane_shift u_ck (
    .clk(clk), .rst_n(rst_int_n), .clr(pdown), .din(rx_clk_lane), .win(ck_win)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] win;
    desrx_lane_shift u_sh (
      .clk(clk), .rst_n(rst_int_n), .clr(pdown), .din(rx_dat_lane[l]), .win(win)
    );
    assign par[l*SLOTS +: SLOTS] = win;
  end

  desrx_framer u_fr (
    .clk(clk), .rst_n(rst_int_n), .clr(pdown), .ck_win(ck_win),
    .capture(capture), .locked(locked)
  );

  desrx_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_int_n), .clr(pdown), .capture(capture), .par(par),
    .word_q(word_q), .valid_q(valid_q)
  );

  assign word_o  = pdown ? '0 : word_q;
  assign valid_o = valid_q & ~pdown;
endmodule

// File: rtl/desrx_chk.sv
module desrx_chk
  import desrx_pkg::*;
#(
  parameter int unsigned DW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pdown,
  input logic          locked,
  input logic [DW-1:0] word_o,
  input logic          valid_o
);
  logic [5:0] gap, since_pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '1;
      since_pd <= '0;
    end else begin
      gap      <= valid_o ? '0 : ((gap == '1) ? gap : gap + 1'b1);
      since_pd <= pdown ? '0 : ((since_pd == '1) ? since_pd : since_pd + 1'b1);
    end
  end

  AST_PDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |-> (!valid_o && word_o == '0));                               // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);                                               // R3
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (gap >= 6'(SLOTS - 1)));                                 // R3
  AST_RELOCK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (since_pd >= 6'(2 * SLOTS)));                            // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !pdown && !$past(pdown)) |-> $stable(word_o));          // R10
  AST_LOCK_FROM_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown) |=> !locked);                                                // R8
endmodule

bind desrx_top desrx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pdown(pdown), .locked(locked),
  .word_o(word_o), .valid_o(valid_o)
);

// File: tb/desrx_top_test.sv
module desrx_top_test;
  localparam int DW = 21;
  localparam logic [6:0] SHAPE = 7'b0001111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdown = 1'b0;
  logic ck_lane = 1'b0;
  logic [2:0] dat = '0;
  logic [DW-1:0] word_o;
  logic valid_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mcnt = 0;
  logic mon_on = 1'b0;
  logic [DW-1:0] last_word = '0;

  typedef struct { logic [DW-1:0] w; int t; } exp_t;
  exp_t q[$];

  desrx_top uut (
    .clk(clk), .rst_n(rst_n), .pdown(pdown), .rx_clk_lane(ck_lane),
    .rx_dat_lane(dat), .word_o(word_o), .valid_o(valid_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic lane_bit(logic [DW-1:0] w, int lane, int slot);
    return w[lane*7 + slot];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic send_frame(input bit good, input logic [DW-1:0] w, input bit pd);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); #2;
      if (i == 0) begin
        if (pd && !pdown) q.delete();
        pdown = pd;
      end
      ck_lane = good ? SHAPE[i] : 1'b0;
      for (int l = 0; l < 3; l++) dat[l] = lane_bit(w, l, i);
      if (i == 6) begin
        if (pd) mcnt = 0;
        else if (good) begin
          mcnt++;
          if (mcnt >= 2) q.push_back('{w: w, t: cyc + 9});
        end else mcnt = 0;
      end
    end
  endtask

  // monitor, away from the driving instant
  always @(negedge clk) begin
    if (mon_on) begin
      if (pdown) begin
        chk(word_o == '0 && !valid_o, "R7 outputs in power-down", word_o, '0);
        last_word = '0;
      end else if (valid_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 R8 unexpected strobe", word_o, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.t, "R4 R2 R5 R6 strobe timing", DW'(cyc), DW'(e.t));
          chk(word_o == e.w, "R1 word content", word_o, e.w);
        end
        last_word = word_o;
      end else begin
        chk(word_o == last_word, "R10 word hold", word_o, last_word);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(word_o == '0 && !valid_o, "R9 reset state", word_o, '0);
    mon_on = 1'b1;
    // unaligned idle slots before the first frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2 ck_lane = 1'b0; dat = 3'b101;
    end
    // directed corner words
    send_frame(1, 21'h000001, 0);
    send_frame(1, 21'h000001, 0);
    send_frame(1, 21'h100000, 0);
    send_frame(1, 21'h1FFFFF, 0);
    send_frame(1, 21'h000000, 0);
    send_frame(1, 21'h0000FE, 0);
    // lock loss right after a locked frame (R5, R6)
    send_frame(0, 21'h155555, 0);
    send_frame(1, 21'h0AAAAA, 0);
    send_frame(1, 21'h123456, 0);
    // power-down landing on a capture edge (R7, R8)
    send_frame(1, 21'h1E0F0F, 1);
    send_frame(1, 21'h0F0F0F, 1);
    send_frame(1, 21'h054321, 0);
    send_frame(1, 21'h0ABCDE, 0);
    send_frame(1, 21'h1DCBA9, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      r = $urandom % 100;
      send_frame(r >= 15, DW'($urandom), (r < 4));
    end
    for (int n = 0; n < 4; n++) send_frame(1, DW'($urandom), 0);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2 R5 all expected words delivered", DW'(q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule